// File: doc/BRIEF.md
# DCO Ratio Fixed-Point Encoder

This block converts a requested oscillator (DCO) frequency, given in whole MHz, and the frequency of the reference clock, given in kHz, into the multiplier setting of a fractional PLL. The multiplier is the integer field plus the fraction field divided by 2^15. The block returns the integer field, the fraction field, and both packed into one 32-bit configuration word that can be written to the PLL unchanged.

A start pulse captures the two inputs. A 38.4 MHz reference is first reduced to 19.2 MHz, because the clock path halves that reference ahead of the PLL. The block then scales the DCO value to kHz and runs a restoring shift-subtract division with one quotient bit per clock. The quotient carries 15 fraction bits. If the division leaves a remainder, the fraction is rounded up by one.

When the division ends, the block gives a one-cycle done pulse. A reference value outside the legal set gives a one-cycle error pulse and no division. The results stay on the outputs until the next start that the block accepts.

Top module: `dco_ratio_encoder`

## Requirements
- R1: After reset, done, err and busy are 0, and dco_int, dco_frac and cfg_word are all 0.
- R2: A ref_khz of 38400 gives exactly the same results as a ref_khz of 19200.
- R3: The accepted ref_khz values are 24000, 19200 and 38400. For any other value, a start gives a one-cycle err pulse in the cycle after the start edge, busy stays 0, no done follows, and the previous results are kept.
- R4: dco_int equals floor(dco_mhz * 1000 / ref), where ref is the effective reference in kHz.
- R5: dco_frac equals ceil(dco_mhz * 1000 * 2^15 / ref) - dco_int * 2^15. An exact division gives a fraction with no round-up, and the result never exceeds 32767.
- R6: In cfg_word, dco_int sits in bits [9:0] and dco_frac sits in bits [24:10]. Bits [31:25] are 0.
- R7: For an accepted start, busy is high from the following cycle, and done is a single-cycle pulse that is seen 39 clock edges after the start edge.
- R8: A start that arrives while busy is 1 is ignored, and the results that follow belong to the request already running.
- R9: Once done has pulsed, dco_int, dco_frac and cfg_word hold their values until another start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; inputs are captured when the block is idle |
| dco_mhz | input | 14 | Target DCO frequency in MHz |
| ref_khz | input | 16 | Reference clock frequency in kHz |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when the results are ready |
| err | output | 1 | One-cycle pulse when the reference value is illegal |
| dco_int | output | 10 | Integer part of the multiplier |
| dco_frac | output | 15 | Fraction of the multiplier in units of 2^-15 |
| cfg_word | output | 32 | Packed configuration word |

## Verification
The assertions assume that dco_mhz is small enough for the integer ratio to fit in 10 bits. With the 14-bit input this always holds, because 16383 MHz over 19.2 MHz is 853. They also assume that only the three legal references start a division.

The random stimulus draws DCO values from the operating band 7998 to 10000 MHz and picks the reference from the legal set. Directed cases then cover the widest input value, ratios that divide exactly, the halved reference, an illegal reference, and a start pulse issued in the middle of a division.

// File: rtl/dco_enc_pkg.sv
package dco_enc_pkg;

   // Legal reference clock values in kHz
   localparam int unsigned REF_KHZ_24   = 24000;
   localparam int unsigned REF_KHZ_19P2 = 19200;
   localparam int unsigned REF_KHZ_38P4 = 38400;

   // Scale from MHz to kHz applied to the DCO target
   localparam int unsigned KHZ_PER_MHZ  = 1000;

   // Which reference was recognised
   typedef enum logic [1:0] {
      REF_SEL_NONE   = 2'd0,
      REF_SEL_24     = 2'd1,
      REF_SEL_19P2   = 2'd2,
      REF_SEL_HALVED = 2'd3
   } ref_sel_e;

endpackage

// File: rtl/ref_normalizer.sv
module ref_normalizer
   import dco_enc_pkg::*;
#(
   parameter int REF_W = 16
) (
   input  logic [REF_W-1:0] ref_khz,
   output logic [REF_W-1:0] ref_eff,
   output logic             ref_legal,
   output ref_sel_e         ref_sel
);

   if (REF_W < 16) begin : g_bad_width
      $error("ref_normalizer: REF_W must hold 38400");
   end

   localparam logic [REF_W-1:0] K24   = REF_W'(REF_KHZ_24);
   localparam logic [REF_W-1:0] K19P2 = REF_W'(REF_KHZ_19P2);
   localparam logic [REF_W-1:0] K38P4 = REF_W'(REF_KHZ_38P4);

   always_comb begin
      ref_eff   = '0;
      ref_legal = 1'b0;
      ref_sel   = REF_SEL_NONE;
      if (ref_khz == K24) begin
         ref_eff   = K24;
         ref_legal = 1'b1;
         ref_sel   = REF_SEL_24;
      end else if (ref_khz == K19P2) begin
         ref_eff   = K19P2;
         ref_legal = 1'b1;
         ref_sel   = REF_SEL_19P2;
      end else if (ref_khz == K38P4) begin
         // the clock path halves this reference ahead of the PLL
         ref_eff   = K19P2;
         ref_legal = 1'b1;
         ref_sel   = REF_SEL_HALVED;
      end
   end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
   parameter int QW   = 39,
   parameter int DV_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [QW-1:0]   dividend,
   input  logic [DV_W-1:0] divisor,
   output logic            busy,
   output logic            done,
   output logic [QW-1:0]   quotient,
   output logic            rem_nz
);

   localparam int CNT_W = $clog2(QW + 1);

   if (QW < 2) begin : g_bad_qw
      $error("restoring_divider: QW must be at least 2");
   end

   logic [QW-1:0]   dvd_q;
   logic [DV_W-1:0] div_q;
   logic [DV_W-1:0] rem_q;
   logic [CNT_W-1:0] cnt_q;

   logic [DV_W:0] trial;
   logic [DV_W:0] trial_sub;
   logic          ge;

   always_comb begin
      trial     = {rem_q, dvd_q[QW-1]};
      ge        = (trial >= {1'b0, div_q});
      trial_sub = trial - {1'b0, div_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_q    <= '0;
         div_q    <= '0;
         rem_q    <= '0;
         cnt_q    <= '0;
         quotient <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load && !busy) begin
            dvd_q    <= dividend;
            div_q    <= divisor;
            rem_q    <= '0;
            quotient <= '0;
            cnt_q    <= CNT_W'(QW);
            busy     <= 1'b1;
         end else if (busy) begin
            dvd_q    <= {dvd_q[QW-2:0], 1'b0};
            quotient <= {quotient[QW-2:0], ge};
            rem_q    <= ge ? trial_sub[DV_W-1:0] : trial[DV_W-1:0];
            cnt_q    <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign rem_nz = |rem_q;

   // partial remainder never reaches the divisor during a run (R4)
   assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem_q < div_q))
      else $error("remainder reached divisor");

   // busy only drops when a result is delivered (R7)
   assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done)
      else $error("busy fell without done");

   // done is a single-cycle pulse (R7)
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   // a load while running does not restart the count (R8)
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1))
      else $error("load disturbed a running division");

endmodule

// File: rtl/ratio_packer.sv
module ratio_packer #(
   parameter int QW       = 39,
   parameter int INT_W    = 10,
   parameter int FRAC_W   = 15,
   parameter int FRAC_LSB = 10,
   parameter int WORD_W   = 32,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic [QW-1:0]     quotient,
   input  logic              rem_nz,
   output logic [INT_W-1:0]  dco_int,
   output logic [FRAC_W-1:0] dco_frac,
   output logic [WORD_W-1:0] cfg_word,
   output logic              int_ovf,
   output logic              frac_carry
);

   if (FRAC_LSB < INT_W) begin : g_bad_overlap
      $error("ratio_packer: fraction field overlaps integer field");
   end
   if (FRAC_LSB + FRAC_W > WORD_W) begin : g_bad_word
      $error("ratio_packer: fraction field exceeds word");
   end
   if (QW < FRAC_W + INT_W) begin : g_bad_qw
      $error("ratio_packer: quotient narrower than fields");
   end

   localparam int TOP_W = QW - FRAC_W - INT_W;

   logic [FRAC_W:0] frac_sum;

   if (ROUND_UP) begin : g_ceil
      always_comb frac_sum = {1'b0, quotient[FRAC_W-1:0]} + {{FRAC_W{1'b0}}, rem_nz};
   end else begin : g_floor
      logic unused_rem;
      assign unused_rem = rem_nz;
      always_comb frac_sum = {1'b0, quotient[FRAC_W-1:0]};
   end

   if (TOP_W > 0) begin : g_ovf
      assign int_ovf = |quotient[QW-1:FRAC_W+INT_W];
   end else begin : g_no_ovf
      assign int_ovf = 1'b0;
   end

   assign dco_int    = quotient[FRAC_W +: INT_W];
   assign dco_frac   = frac_sum[FRAC_W-1:0];
   assign frac_carry = frac_sum[FRAC_W];

   always_comb begin
      cfg_word                      = '0;
      cfg_word[INT_W-1:0]           = dco_int;
      cfg_word[FRAC_LSB +: FRAC_W]  = dco_frac;
   end

endmodule

// File: rtl/dco_ratio_encoder.sv
module dco_ratio_encoder
   import dco_enc_pkg::*;
#(
   parameter int DCO_W    = 14,
   parameter int REF_W    = 16,
   parameter int INT_W    = 10,
   parameter int FRAC_W   = 15,
   parameter int FRAC_LSB = 10,
   parameter int WORD_W   = 32,
   parameter bit ROUND_UP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DCO_W-1:0]  dco_mhz,
   input  logic [REF_W-1:0]  ref_khz,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [INT_W-1:0]  dco_int,
   output logic [FRAC_W-1:0] dco_frac,
   output logic [WORD_W-1:0] cfg_word
);

   localparam int SCALE_W = $clog2(KHZ_PER_MHZ);
   localparam int NUM_W   = DCO_W + SCALE_W;
   localparam int QW      = NUM_W + FRAC_W;

   if (DCO_W < 1 || FRAC_W < 1 || INT_W < 1) begin : g_bad_param
      $error("dco_ratio_encoder: field widths must be positive");
   end

   logic [REF_W-1:0] ref_eff;
   logic             ref_legal;
   ref_sel_e         ref_sel;
   logic [NUM_W-1:0] num_khz;
   logic [QW-1:0]    dividend;
   logic [QW-1:0]    quotient;
   logic             rem_nz;
   logic             accept;
   logic             int_ovf;
   logic             frac_carry;

   ref_normalizer #(.REF_W(REF_W)) u_ref (
      .ref_khz   (ref_khz),
      .ref_eff   (ref_eff),
      .ref_legal (ref_legal),
      .ref_sel   (ref_sel)
   );

   assign num_khz  = NUM_W'(dco_mhz) * NUM_W'(KHZ_PER_MHZ);
   assign dividend = {num_khz, {FRAC_W{1'b0}}};
   assign accept   = start && !busy;

   restoring_divider #(.QW(QW), .DV_W(REF_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && ref_legal),
      .dividend (dividend),
      .divisor  (ref_eff),
      .busy     (busy),
      .done     (done),
      .quotient (quotient),
      .rem_nz   (rem_nz)
   );

   ratio_packer #(
      .QW(QW), .INT_W(INT_W), .FRAC_W(FRAC_W),
      .FRAC_LSB(FRAC_LSB), .WORD_W(WORD_W), .ROUND_UP(ROUND_UP)
   ) u_pack (
      .quotient   (quotient),
      .rem_nz     (rem_nz),
      .dco_int    (dco_int),
      .dco_frac   (dco_frac),
      .cfg_word   (cfg_word),
      .int_ovf    (int_ovf),
      .frac_carry (frac_carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else        err <= accept && !ref_legal;
   end

   // err only follows an idle start with an illegal reference (R3)
   assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($past(start) && !$past(busy) && ($past(ref_sel) == REF_SEL_NONE)))
      else $error("err without illegal request");

   // an illegal reference never starts a division (R3)
   assert_err_no_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy && !done)
      else $error("err together with busy or done");

   // integer ratio fits its field (R4)
   assert_int_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !int_ovf)
      else $error("integer ratio overflows field");

   // rounded fraction never wraps (R5)
   assert_frac_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !frac_carry)
      else $error("fraction round-up carried out");

   // results hold while idle (R9)
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(cfg_word))
      else $error("results changed while idle");

endmodule

// File: tb/test_dco_ratio_encoder.sv
module test_dco_ratio_encoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [13:0] dco_mhz = '0;
   logic [15:0] ref_khz = '0;
   logic        busy, done, err;
   logic [9:0]  dco_int;
   logic [14:0] dco_frac;
   logic [31:0] cfg_word;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit ended = 1'b0;

   always #4 clk = ~clk;

   dco_ratio_encoder i_dco_ratio_encoder (
      .clk(clk), .rst_n(rst_n), .start(start), .dco_mhz(dco_mhz),
      .ref_khz(ref_khz), .busy(busy), .done(done), .err(err),
      .dco_int(dco_int), .dco_frac(dco_frac), .cfg_word(cfg_word)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint eff_ref(input int rf);
      return (rf == 38400) ? 64'd19200 : longint'(rf);
   endfunction

   function automatic longint exp_int(input int dco, input int rf);
      return (longint'(dco) * 1000) / eff_ref(rf);
   endfunction

   function automatic longint exp_frac(input int dco, input int rf);
      longint n = longint'(dco) * 1000 * 32768;
      longint r = eff_ref(rf);
      longint q = n / r;
      return (q % 32768) + ((n % r) != 0 ? 1 : 0);
   endfunction

   function automatic longint exp_word(input int dco, input int rf);
      return exp_int(dco, rf) | (exp_frac(dco, rf) << 10);
   endfunction

   task automatic finish_up();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // issue a request; optionally a second start at cycle poke_at; returns latency
   task automatic launch(input int dco, input int rf, input int poke_at, output int lat);
      @(negedge clk);
      start = 1'b1; dco_mhz = 14'(dco); ref_khz = 16'(rf);
      @(negedge clk);
      start = 1'b0;
      lat = -1;
      for (int k = 1; k <= 100; k++) begin
         @(negedge clk);
         if (k == poke_at) begin
            start = 1'b1; dco_mhz = 14'd9999; ref_khz = 16'd24000;
         end else begin
            start = 1'b0;
         end
         if (done) begin
            lat = k;
            break;
         end
      end
      start = 1'b0;
   endtask

   task automatic check_results(input string tag, input int dco, input int rf);
      chk({tag, " R4 int"}, longint'(dco_int), exp_int(dco, rf));
      chk({tag, " R5 frac"}, longint'(dco_frac), exp_frac(dco, rf));
      chk({tag, " R6 word"}, longint'(cfg_word), exp_word(dco, rf));
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 200000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
            finish_up();
         end
      end
   end

   initial begin
      int lat;
      int ref_pick [3] = '{24000, 19200, 38400};
      void'($urandom(32'd20240));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 done", longint'(done), 0);
      chk("R1 err", longint'(err), 0);
      chk("R1 busy", longint'(busy), 0);
      chk("R1 word", longint'(cfg_word), 0);

      // R7 latency and busy, plus R4/R5/R6 exact-half case
      launch(8100, 24000, 0, lat);
      chk("R7 latency", lat, 39);
      check_results("8100/24000", 8100, 24000);
      chk("R5 half frac", longint'(dco_frac), 16384);

      // R5 exact division: no round-up
      launch(9600, 19200, 0, lat);
      check_results("9600/19200", 9600, 19200);
      chk("R5 exact frac zero", longint'(dco_frac), 0);

      // R2 halved reference matches 19200
      launch(9000, 38400, 0, lat);
      check_results("9000/38400", 9000, 38400);
      chk("R2 same as 19200", longint'(cfg_word), exp_word(9000, 19200));

      // R5 rounding up a non-terminating fraction
      launch(8090, 24000, 0, lat);
      check_results("8090/24000", 8090, 24000);

      // R4 widest input
      launch(16383, 19200, 0, lat);
      check_results("16383/19200", 16383, 19200);

      // R9 hold after done
      repeat (5) @(negedge clk);
      chk("R9 hold word", longint'(cfg_word), exp_word(16383, 19200));

      // R3 illegal reference
      @(negedge clk);
      start = 1'b1; dco_mhz = 14'd9000; ref_khz = 16'd25000;
      @(negedge clk);
      start = 1'b0;
      chk("R3 err pulse", longint'(err), 1);
      chk("R3 busy low", longint'(busy), 0);
      begin
         int seen_done = 0;
         int seen_err = 0;
         for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done) seen_done++;
            if (err) seen_err++;
         end
         chk("R3 no done", seen_done, 0);
         chk("R3 err one cycle", seen_err, 0);
      end
      chk("R3 results kept", longint'(cfg_word), exp_word(16383, 19200));

      // R8 start during a run is ignored
      launch(8500, 19200, 5, lat);
      chk("R8 latency", lat, 39);
      check_results("R8 8500/19200", 8500, 19200);
      repeat (3) @(negedge clk);
      chk("R8 no second done", longint'(busy), 0);

      // random operating points
      for (int i = 0; i < 40; i++) begin
         int d = 7998 + int'($urandom_range(0, 2002));
         int r = ref_pick[$urandom_range(0, 2)];
         launch(d, r, 0, lat);
         chk("R7 random latency", lat, 39);
         check_results("random", d, r);
      end

      finish_up();
   end

endmodule